// File: doc/BRIEF.md
# Bit-Serial Fractional Multiply Coprocessor

This block is a self-contained multiply engine for 20-bit signed (two's complement) words. The words travel on single-bit lines. A host starts a job with a one-cycle frame strobe. On the strobe cycle and the 19 cycles after it, the host places one bit of the multiplicand on one line and one bit of the multiplier on the other, least significant bit first. After the last bit has arrived, the block forms the full 40-bit product with a radix-2 Booth sequence, one recoding step per clock. The host does other work while this runs.

The product is returned as a fractional Q19 word, with saturation. The previous result leaves on the result line, least significant bit first, during the same cycles in which the next operand pair arrives. Reading a result therefore costs the host no extra cycles. The host learns that a result is ready from a one-cycle done pulse. A strobe sent while the block is occupied is dropped, and the block reports it with an error pulse.

Top module: `sermul_cop`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `res_ser_o` are 0, and the first result word shifted out is zero.
- R2: A strobe on `frame_i` while `busy_o` is low starts a job. Bit k of each operand (k = 0..19, bit 0 first, bit 19 the sign) is sampled in the k-th cycle counted from the strobe cycle as cycle 0.
- R3: `busy_o` is high from the cycle after the accepting strobe for exactly 39 cycles.
- R4: The result word equals the signed 40-bit product of the two operands shifted arithmetically right by 19 bits (product bits 38..19). Rounding is toward minus infinity.
- R5: When the shifted product exceeds +524287, the word saturates to 0x7FFFF. The only such case is 0x80000 times 0x80000.
- R6: The result of a job is shifted out on `res_ser_o`, least significant bit first. Result bit k is on the line during cycle k of the next accepted frame. Until that frame arrives, the line holds bit 0.
- R7: `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low again.
- R8: A strobe that arrives while `busy_o` is high is ignored. `err_o` is high during the following cycle only. The running job's timing and result do not change.
- R9: A new frame may start in the cycle in which `done_o` is high, so jobs can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | One-cycle strobe marking operand bit 0 |
| a_ser_i | input | 1 | Serial multiplicand, LSB first |
| b_ser_i | input | 1 | Serial multiplier, LSB first |
| res_ser_o | output | 1 | Serial result of the previous job, LSB first |
| busy_o | output | 1 | Operand load or Booth sequence in progress |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| err_o | output | 1 | One-cycle pulse after an ignored strobe |

## Verification
The bench builds the block with its default parameters: 20-bit words, a 19-bit fractional shift and saturation enabled. These settings make the single overflow case reachable (the most negative word squared). They also expose the floor rounding of tiny negative products and the sign-extension path for 0x80000 times 0x7FFFF. Back-to-back jobs in the done cycle and dropped strobes during both the load phase and the Booth phase are exercised against the 39-cycle busy window.

// File: rtl/sermul_pkg.sv
package sermul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_CALC = 2'd2
    } sermul_st_e;

endpackage

// File: rtl/sermul_booth_step.sv
// One radix-2 Booth step: recode (q0, q-1), add or subtract the
// multiplicand, then arithmetic right shift of {acc, q, q-1}.
module sermul_booth_step #(
    parameter int W = 20
) (
    input  logic [W:0]   acc_i,
    input  logic [W-1:0] q_i,
    input  logic         qm1_i,
    input  logic [W-1:0] mcand_i,
    output logic [W:0]   acc_o,
    output logic [W-1:0] q_o,
    output logic         qm1_o
);
    logic [W:0] mext;
    logic [W:0] sum;

    always_comb begin
        mext = {mcand_i[W-1], mcand_i};
        unique case ({q_i[0], qm1_i})
            2'b01:   sum = acc_i + mext;
            2'b10:   sum = acc_i - mext;
            default: sum = acc_i;
        endcase
        acc_o = {sum[W], sum[W:1]};
        q_o   = {sum[0], q_i[W-1:1]};
        qm1_o = q_i[0];
    end

endmodule

// File: rtl/sermul_scale.sv
// Picks the fractional output window from the full product and clamps it.
module sermul_scale #(
    parameter int W        = 20,
    parameter int FRAC     = 19,
    parameter bit SATURATE = 1'b1
) (
    input  logic [2*W-1:0] prod_i,
    output logic [W-1:0]   word_o
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] sh;
    assign sh = $signed(prod_i) >>> FRAC;

    generate
        if (SATURATE) begin : g_sat
            logic [PW-W:0] hi;
            logic          fits;
            assign hi   = sh[PW-1:W-1];
            assign fits = (&hi) | ~(|hi);
            always_comb begin
                if (fits)
                    word_o = sh[W-1:0];
                else if (sh[PW-1])
                    word_o = {1'b1, {(W-1){1'b0}}};
                else
                    word_o = {1'b0, {(W-1){1'b1}}};
            end
        end else begin : g_wrap
            assign word_o = sh[W-1:0];
        end
    endgenerate

endmodule

// File: rtl/sermul_cop.sv
module sermul_cop #(
    parameter int W        = 20,
    parameter int FRAC     = 19,
    parameter bit SATURATE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic a_ser_i,
    input  logic b_ser_i,
    output logic res_ser_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    import sermul_pkg::*;

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        sermul_st_e     st;
        logic [CW-1:0]  cnt;
        logic [W-1:0]   a_sr;   // multiplicand
        logic [W-1:0]   b_sr;   // multiplier, becomes low product half
        logic [W:0]     acc;
        logic           qm1;
        logic [W-1:0]   out_sr;
        logic           done;
        logic           err;
    } sermul_regs_t;

    sermul_regs_t r_q, r_d;

    logic [W:0]     step_acc;
    logic [W-1:0]   step_q;
    logic           step_qm1;
    logic [W-1:0]   scaled;
    logic [W-1:0]   a_next;
    logic [W-1:0]   b_next;

    sermul_booth_step #(.W(W)) u_step (
        .acc_i   (r_q.acc),
        .q_i     (r_q.b_sr),
        .qm1_i   (r_q.qm1),
        .mcand_i (r_q.a_sr),
        .acc_o   (step_acc),
        .q_o     (step_q),
        .qm1_o   (step_qm1)
    );

    sermul_scale #(.W(W), .FRAC(FRAC), .SATURATE(SATURATE)) u_scale (
        .prod_i (({step_acc[W-1:0], step_q})),
        .word_o (scaled)
    );

    assign a_next = {a_ser_i, r_q.a_sr[W-1:1]};
    assign b_next = {b_ser_i, r_q.b_sr[W-1:1]};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = frame_i && (r_q.st != ST_IDLE);
        unique case (r_q.st)
            ST_IDLE: begin
                if (frame_i) begin
                    r_d.a_sr   = a_next;
                    r_d.b_sr   = b_next;
                    r_d.cnt    = CW'(1);
                    r_d.st     = ST_LOAD;
                    r_d.out_sr = {1'b0, r_q.out_sr[W-1:1]};
                end
            end
            ST_LOAD: begin
                r_d.a_sr   = a_next;
                r_d.b_sr   = b_next;
                r_d.out_sr = {1'b0, r_q.out_sr[W-1:1]};
                if (r_q.cnt == LAST) begin
                    r_d.st  = ST_CALC;
                    r_d.cnt = '0;
                    r_d.acc = '0;
                    r_d.qm1 = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_CALC: begin
                r_d.acc  = step_acc;
                r_d.b_sr = step_q;
                r_d.qm1  = step_qm1;
                if (r_q.cnt == LAST) begin
                    r_d.st     = ST_IDLE;
                    r_d.cnt    = '0;
                    r_d.done   = 1'b1;
                    r_d.out_sr = scaled;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign res_ser_o = r_q.out_sr[0];
    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign err_o     = r_q.err;

endmodule

// File: rtl/sermul_chk.sv
module sermul_chk #(
    parameter int W = 20
) (
    input logic clk,
    input logic rst_n,
    input logic frame_i,
    input logic res_ser_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);
    localparam int BUSY_LEN = 2 * W - 1;

    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt <= 0;
        else if (busy_o)
            busy_cnt <= busy_cnt + 1;
        else
            busy_cnt <= 0;
    end

    // R2 / R3: an accepted strobe makes the block busy next cycle
    a_r3_busy_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && !busy_o) |=> busy_o);

    // R3: busy window length
    a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt == BUSY_LEN));

    // R7: done is a single pulse while idle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: error pulse follows exactly the ignored strobes
    a_r8_err_on_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && busy_o) |=> err_o);
    a_r8_no_spurious_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_i && busy_o) |=> !err_o);

    // R6: result line holds while idle and no frame
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !frame_i) |=> $stable(res_ser_o));

endmodule

bind sermul_cop sermul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_i   (frame_i),
    .res_ser_o (res_ser_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/sermul_cop_bench.sv
module sermul_cop_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_i = 1'b0;
    logic a_ser_i = 1'b0;
    logic b_ser_i = 1'b0;
    logic res_ser_o, busy_o, done_o, err_o;

    int checks = 0;
    int failures = 0;
    logic run = 1'b0;
    logic [19:0] sb[$];

    always #2 clk = ~clk;

    sermul_cop u_sermul_cop (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .a_ser_i(a_ser_i),
        .b_ser_i(b_ser_i), .res_ser_o(res_ser_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [19:0] model(input logic [19:0] a, input logic [19:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        p = p >>> 19;
        if (p > 524287) p = 524287;
        return p[19:0];
    endfunction

    // Driver: caller is aligned 1 ns after a rising edge.
    task automatic send(input logic [19:0] a, input logic [19:0] b, input int glitch);
        while (busy_o) begin @(posedge clk); #1; end
        sb.push_back(model(a, b));
        for (int c = 0; c < 40; c++) begin
            frame_i = (c == 0) || (c == glitch);
            a_ser_i = (c < 20) ? a[c] : 1'b1;
            b_ser_i = (c < 20) ? b[c] : 1'b1;
            @(posedge clk); #1;
        end
        frame_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    // Monitor / scoreboard
    int mpos = -1;
    logic [19:0] word;
    logic [19:0] expw;
    logic prev_ign = 1'b0;
    always @(negedge clk) begin
        if (run) begin
            if (mpos >= 0) begin
                mpos++;
                if (mpos <= 19) word[mpos] = res_ser_o;
                if (mpos == 19) begin
                    checks++;
                    if (sb.size() == 0) begin
                        failures++;
                        $display("FAIL R4/R6: result %h with empty scoreboard", word);
                    end else begin
                        expw = sb.pop_front();
                        if (word !== expw) begin
                            failures++;
                            $display("FAIL R4/R5/R6: result actual=%h expected=%h", word, expw);
                        end
                    end
                end
                if (mpos >= 1 && mpos <= 39 && (busy_o !== 1'b1 || done_o !== 1'b0)) begin
                    failures++;
                    $display("FAIL R3: cycle %0d busy=%b done=%b expected busy=1 done=0",
                             mpos, busy_o, done_o);
                end
                if (mpos == 40) begin
                    checks++;
                    if (busy_o !== 1'b0 || done_o !== 1'b1) begin
                        failures++;
                        $display("FAIL R7: busy=%b done=%b expected busy=0 done=1", busy_o, done_o);
                    end
                    mpos = -1;
                end
            end
            if (mpos < 0 && frame_i && !busy_o) begin
                mpos = 0;
                word[0] = res_ser_o;
            end
            // R8 error pulse tracking
            if (err_o !== prev_ign) begin
                failures++;
                $display("FAIL R8: err actual=%b expected=%b", err_o, prev_ign);
            end
            if (prev_ign) checks++;
            prev_ign = frame_i && busy_o;
        end
    end

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({busy_o, done_o, err_o, res_ser_o} !== 4'b0) begin
            failures++;
            $display("FAIL R1: outputs actual=%b expected=0000", {busy_o, done_o, err_o, res_ser_o});
        end
        run = 1'b1;
        sb.push_back(20'h0);                     // R1: reset result word
        @(posedge clk); #1;
        send(20'h40000, 20'h40000, -1);          // R4: 0.5*0.5
        send(20'hC0000, 20'h40000, -1);          // R4: -0.5*0.5, back-to-back R9
        send(20'h80000, 20'h80000, -1);          // R5: saturation
        idle(7);
        send(20'h80000, 20'h7FFFF, -1);          // R4: most negative times max
        send(20'h00001, 20'hFFFFF, -1);          // R4: floor of tiny negative
        send(20'h7FFFF, 20'h7FFFF, -1);          // R4: max squared
        send(20'h12345, 20'hABCDE, 5);           // R8: strobe during load
        send(20'h55555, 20'h2AAAA, 30);          // R8: strobe during Booth phase
        send(20'h00000, 20'h6789A, -1);          // R4: zero operand
        for (int i = 0; i < 8; i++)
            send(20'($urandom), 20'($urandom), (i == 3) ? 38 : -1);   // R2/R4 mixed patterns
        idle(3);
        send(20'h00000, 20'h00000, -1);          // flush last result (R6)
        idle(45);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule